// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block receives audio samples over a three-wire serial link (bit clock, serial data and a latch strobe) and presents each one as a parallel 18-bit two's-complement word. Every rising bit-clock edge shifts one data bit into a shift register, most significant bit first. Frames may carry more than 18 clocks, up to 24 per word. Only the last 18 bits shifted in before the strobe drops are kept.

The strobe is checked for dwell time. It must have been seen high on at least `MIN_HI` consecutive rising edges before it falls. After it falls, it must be seen low on at least `MIN_LO` consecutive rising edges, counting the edge that saw the fall. When both hold, the shifted word is copied into a holding register and `word_valid` pulses for one bit-clock cycle. A strobe that breaks either rule sets a sticky protocol-error flag and commits nothing.

The strobe may stay low while the bit clock is stopped between words. Restarting the clock with the strobe low does not latch a second time. Each commit is also carried to a second clock domain as a single-cycle pulse. Both domains use an asynchronous active-low reset whose release is synchronised to that domain's clock.

Top module: `srx_word_rx`

## Requirements
- R1: While `rst_n` is low, `word_out` is 0 (mid-scale), and `word_valid`, `proto_err` and `dst_valid` are 0.
- R2: Data is sampled on rising `bclk` edges, most significant bit first, and `word_out` is the 18-bit two's-complement word: bit 17 is the first of the 18 kept bits and bit 0 the last.
- R3: After a qualified strobe fall, `word_valid` is high for exactly one `bclk` cycle. That cycle follows the edge that sees the strobe low for the second consecutive time (`MIN_LO` = 2). `word_out` shows the new word in that same cycle.
- R4: If a frame carries more than 18 bits (up to 24), `word_out` holds the last 18 bits shifted in before the edge that first sees the strobe low.
- R5: If the strobe falls after fewer than `MIN_HI` = 2 consecutive high samples, nothing is committed and `proto_err` is set.
- R6: If the strobe returns high before `MIN_LO` low samples, nothing is committed, `proto_err` is set and `word_out` keeps its previous value.
- R7: With the strobe held low, stopping and restarting `bclk` produces no extra commit.
- R8: `word_out` changes only in cycles in which `word_valid` is high.
- R9: `proto_err` stays set until `err_clr` is sampled high on a rising `bclk` edge, which clears it.
- R10: Every commit produces exactly one single-cycle `dst_valid` pulse in the `dst_clk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sdata | input | 1 | Serial data, MSB first |
| latch_en | input | 1 | Latch strobe; a qualified falling edge commits the word |
| err_clr | input | 1 | Clears the protocol-error flag (bclk domain) |
| word_out | output | 18 | Held two's-complement sample |
| word_valid | output | 1 | One-cycle commit pulse (bclk domain) |
| proto_err | output | 1 | Sticky strobe-timing error flag |
| dst_clk | input | 1 | Consumer-domain clock |
| dst_valid | output | 1 | One-cycle commit pulse in the dst_clk domain |

## Verification
The assertions assume that `sdata`, `latch_en` and `err_clr` change away from the rising `bclk` edge. They also assume that commits are spaced further apart than the synchroniser latency in the `dst_clk` domain, which is what makes each `dst_valid` pulse distinct. The stimulus changes every input on the falling `bclk` edge. Every frame is at least 18 clocks long, so commits stay many `dst_clk` cycles apart. Strobe violations are produced on purpose by shortening the high or low dwell to a single sample.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SAMPLE_W = 18;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync (
  input  logic clk,
  input  logic arst_b,
  output logic rst_b
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_b) begin
    if (!arst_b) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign rst_b = stg_q[1];
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_b,
  input  logic         din,
  output logic [W-1:0] sh
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  // Oldest bit leaves at the top, so only the last W bits remain.
  always_comb sh_d = {sh_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sh = sh_q;
endmodule

// File: rtl/srx_latch_qual.sv
module srx_latch_qual #(
  parameter int unsigned MIN_HI = 2,
  parameter int unsigned MIN_LO = 2
) (
  input  logic clk,
  input  logic rst_b,
  input  logic le,
  output logic cap,
  output logic commit,
  output logic err_set,
  output logic pend
);
  localparam int unsigned HI_W = $clog2(MIN_HI + 1);
  localparam int unsigned LO_W = $clog2(MIN_LO + 1);

  logic            le_q,   le_d;
  logic [HI_W-1:0] hi_q,   hi_d;
  logic [LO_W-1:0] lo_q,   lo_d;
  logic            pend_q, pend_d;
  logic            fall;
  logic            hi_ok;

  always_comb begin
    fall    = le_q & ~le;
    hi_ok   = (hi_q >= HI_W'(MIN_HI));
    le_d    = le;
    hi_d    = le ? ((hi_q == HI_W'(MIN_HI)) ? hi_q : hi_q + 1'b1) : '0;
    lo_d    = lo_q;
    pend_d  = pend_q;
    cap     = 1'b0;
    commit  = 1'b0;
    err_set = 1'b0;
    if (pend_q) begin
      if (le) begin
        pend_d  = 1'b0;
        err_set = 1'b1;
      end else if ((lo_q + 1'b1) >= LO_W'(MIN_LO)) begin
        pend_d = 1'b0;
        commit = 1'b1;
      end else begin
        lo_d = lo_q + 1'b1;
      end
    end else if (fall) begin
      if (hi_ok) begin
        pend_d = 1'b1;
        lo_d   = LO_W'(1);
        cap    = 1'b1;
      end else begin
        err_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      le_q   <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      le_q   <= le_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/srx_pulse_sync.sv
module srx_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_b,
  input  logic pulse_in,
  input  logic dst_clk,
  input  logic dst_rst_b,
  output logic pulse_out
);
  logic            tgl_q, tgl_d;
  logic [STAGES:0] chain_q, chain_d;

  always_comb tgl_d = pulse_in ? ~tgl_q : tgl_q;

  always_ff @(posedge src_clk or negedge src_rst_b) begin
    if (!src_rst_b) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  always_comb chain_d = {chain_q[STAGES-1:0], tgl_q};

  always_ff @(posedge dst_clk or negedge dst_rst_b) begin
    if (!dst_rst_b) chain_q <= '0;
    else            chain_q <= chain_d;
  end

  assign pulse_out = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/srx_word_rx.sv
module srx_word_rx
  import srx_pkg::*;
#(
  parameter int unsigned WORD_W      = SAMPLE_W,
  parameter int unsigned MIN_HI      = 2,
  parameter int unsigned MIN_LO      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              latch_en,
  input  logic              err_clr,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              proto_err,
  input  logic              dst_clk,
  output logic              dst_valid
);
  logic              rst_b_bclk;
  logic              dst_rst_b;
  logic [WORD_W-1:0] sh_w;
  logic              cap_w, commit_w, err_w, pend_w;
  logic [WORD_W-1:0] cand_q, cand_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              vld_q,  vld_d;
  logic              err_q,  err_d;

  srx_rst_sync u_rst_b (.clk(bclk),    .arst_b(rst_n), .rst_b(rst_b_bclk));
  srx_rst_sync u_rst_d (.clk(dst_clk), .arst_b(rst_n), .rst_b(dst_rst_b));

  srx_shift #(.W(WORD_W)) u_shift (
    .clk(bclk), .rst_b(rst_b_bclk), .din(sdata), .sh(sh_w)
  );

  srx_latch_qual #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_qual (
    .clk(bclk), .rst_b(rst_b_bclk), .le(latch_en),
    .cap(cap_w), .commit(commit_w), .err_set(err_w), .pend(pend_w)
  );

  // Snapshot is the register before this edge's shift: the bits up to the last high strobe sample.
  always_comb begin
    cand_d = cap_w    ? sh_w   : cand_q;
    hold_d = commit_w ? cand_q : hold_q;
    vld_d  = commit_w;
    err_d  = err_w ? 1'b1 : (err_clr ? 1'b0 : err_q);
  end

  always_ff @(posedge bclk or negedge rst_b_bclk) begin
    if (!rst_b_bclk) begin
      cand_q <= '0;
      hold_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cand_q <= cand_d;
      hold_q <= hold_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  srx_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .src_clk(bclk), .src_rst_b(rst_b_bclk), .pulse_in(vld_q),
    .dst_clk(dst_clk), .dst_rst_b(dst_rst_b), .pulse_out(dst_valid)
  );

  assign word_out   = hold_q;
  assign word_valid = vld_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/srx_word_rx_chk.sv
module srx_word_rx_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              bclk,
  input logic              rst_b,
  input logic              latch_en,
  input logic              err_clr,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid,
  input logic              proto_err,
  input logic              pend,
  input logic              dst_clk,
  input logic              dst_rst_b,
  input logic              dst_valid
);
  p_valid_single_r3: assert property (@(posedge bclk) disable iff (!rst_b)
    word_valid |=> !word_valid);

  p_valid_from_pending_r3: assert property (@(posedge bclk) disable iff (!rst_b)
    word_valid |-> $past(pend));

  p_valid_after_low_r6: assert property (@(posedge bclk) disable iff (!rst_b)
    word_valid |-> !$past(latch_en));

  p_hold_stable_r8: assert property (@(posedge bclk) disable iff (!rst_b)
    !word_valid |-> $stable(word_out));

  p_err_sticky_r9: assert property (@(posedge bclk) disable iff (!rst_b)
    (proto_err && !err_clr) |=> proto_err);

  p_dst_single_r10: assert property (@(posedge dst_clk) disable iff (!dst_rst_b)
    dst_valid |=> !dst_valid);
endmodule

bind srx_word_rx srx_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .bclk(bclk), .rst_b(rst_b_bclk), .latch_en(latch_en), .err_clr(err_clr),
  .word_out(word_out), .word_valid(word_valid), .proto_err(proto_err),
  .pend(pend_w), .dst_clk(dst_clk), .dst_rst_b(dst_rst_b), .dst_valid(dst_valid)
);

// File: tb/test_srx_word_rx.sv
module test_srx_word_rx;
  logic        bclk = 1'b0;
  logic        dst_clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n, sdata, latch_en, err_clr;
  logic [17:0] word_out;
  logic        word_valid, proto_err, dst_valid;

  int          n_chk = 0;
  int          n_err = 0;
  int          n_commit = 0;
  int          n_dst = 0;
  int          n_unexp = 0;
  bit          mon_on = 1'b0;
  logic [17:0] exp_q[$];
  logic [17:0] last_word = '0;

  srx_word_rx i_srx_word_rx (
    .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .latch_en(latch_en),
    .err_clr(err_clr), .word_out(word_out), .word_valid(word_valid),
    .proto_err(proto_err), .dst_clk(dst_clk), .dst_valid(dst_valid)
  );

  always begin #5; if (clk_run) bclk = ~bclk; end
  always #4 dst_clk = ~dst_clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops on every commit, otherwise the held word must not move.
  always @(negedge bclk) begin
    if (mon_on) begin
      if (word_valid) begin
        n_commit++;
        if (exp_q.size() == 0) begin
          n_unexp++;
          chk(1'b0, "R7 unexpected commit", {14'd0, word_out}, 32'd0);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk(word_out == e, "R2/R3/R4 committed word", {14'd0, word_out}, {14'd0, e});
          last_word = e;
        end
      end else begin
        chk(word_out == last_word, "R8 word held", {14'd0, word_out}, {14'd0, last_word});
      end
    end
  end

  always @(negedge dst_clk) if (mon_on && dst_valid) n_dst++;

  // Drive one frame of n bits MSB first; strobe high on the last hi bits, then lo low cycles.
  task automatic send_frame(input logic [23:0] f, input int n, input int hi, input int lo, input bit expect_commit);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge bclk);
      sdata    = f[i];
      latch_en = (i < hi);
    end
    if (expect_commit) exp_q.push_back(f[17:0]);
    @(negedge bclk);
    latch_en = 1'b0;
    sdata    = 1'b0;
    repeat (lo) @(negedge bclk);
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(negedge bclk);
    err_clr = 1'b0;
    @(negedge bclk);
    chk(proto_err == 1'b0, "R9 cleared", {31'd0, proto_err}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog: actual running expected finished");
    n_err++;
    n_chk++;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sdata = 1'b0; latch_en = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge bclk);
    chk(word_out == 18'd0, "R1 word reset", {14'd0, word_out}, 32'd0);
    chk(word_valid == 1'b0, "R1 valid reset", {31'd0, word_valid}, 32'd0);
    chk(proto_err == 1'b0, "R1 error reset", {31'd0, proto_err}, 32'd0);
    chk(dst_valid == 1'b0, "R1 dst reset", {31'd0, dst_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);
    mon_on = 1'b1;

    // R2 / R3: plain 18-bit frames, including extreme two's-complement codes.
    send_frame(24'h02A5C3, 18, 2, 2, 1'b1);
    send_frame(24'h020000, 18, 2, 3, 1'b1);
    send_frame(24'h01FFFF, 18, 3, 2, 1'b1);
    send_frame(24'h03FFFF, 18, 2, 2, 1'b1);
    send_frame(24'h000001, 18, 2, 2, 1'b1);

    // R4: 24-clock frame, top six bits discarded.
    send_frame(24'hFD1234, 24, 2, 2, 1'b1);
    send_frame(24'h5A0F0F, 21, 4, 2, 1'b1);

    // R5: only one high sample before the fall.
    send_frame(24'h011111, 18, 1, 3, 1'b0);
    chk(proto_err == 1'b1, "R5 short high sets error", {31'd0, proto_err}, 32'd1);
    repeat (5) @(negedge bclk);
    chk(proto_err == 1'b1, "R9 error sticky", {31'd0, proto_err}, 32'd1);
    clear_err();

    // R6: strobe returns high after a single low sample.
    send_frame(24'h02BEEF, 18, 2, 1, 1'b0);
    latch_en = 1'b1;
    @(negedge bclk);
    latch_en = 1'b0;
    repeat (4) @(negedge bclk);
    chk(proto_err == 1'b1, "R6 short low sets error", {31'd0, proto_err}, 32'd1);
    chk(word_out == last_word, "R6 word unchanged", {14'd0, word_out}, {14'd0, last_word});
    clear_err();

    // R7: stop the bit clock with the strobe low, then restart.
    send_frame(24'h012345, 18, 2, 2, 1'b1);
    clk_run = 1'b0;
    #200;
    clk_run = 1'b1;
    repeat (3) @(negedge bclk);
    send_frame(24'h0ABCDE, 20, 2, 2, 1'b1);
    clk_run = 1'b0;
    #150;
    clk_run = 1'b1;
    repeat (2) @(negedge bclk);

    // Mixed random frames (R2, R3, R4).
    for (int k = 0; k < 24; k++) begin
      logic [23:0] f;
      int          n;
      f = 24'($urandom);
      n = 18 + int'($urandom_range(6));
      send_frame(f, n, 2 + int'($urandom_range(2)), 2 + int'($urandom_range(2)), 1'b1);
    end

    repeat (10) @(negedge bclk);
    chk(exp_q.size() == 0, "R3 all expected commits seen", exp_q.size(), 32'd0);
    chk(n_unexp == 0, "R7 no spurious commit", n_unexp, 32'd0);
    chk(proto_err == 1'b0, "R9 no error on valid traffic", {31'd0, proto_err}, 32'd0);
    chk(n_dst == n_commit, "R10 one dst pulse per commit", n_dst, n_commit);
    mon_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule